// File: doc/BRIEF.md
# Multi-Mode 16-Bit Measurement Timer

This block is a 16-bit down-counter with a reload latch. Software reaches it through an 8-bit bus. The bus has four byte addresses: the two halves of the timer, a mode register and a real-time port data register. Four modes are available.

- **Plain timer:** decrements once per count-enable strobe.
- **Event counter:** decrements once per selected edge on the external input, and ignores the strobe.
- **Period measurement:** counts like the plain timer, but reloads from the latch on the selected external edge.
- **High/low pulse-width measurement:** counts like the plain timer, but reloads from the latch on every external edge.

In both measurement modes the count just before the edge-triggered reload is frozen, so software can read the measured interval. The block raises one-cycle interrupt pulses on underflow and on qualifying external edges. It also drives a 2-bit output port that takes its stored data at each underflow.

A 16-bit value is written low byte first, then high byte. The transfer happens only when the high byte is written. A 16-bit value is read high byte first, then low byte. The low half is captured during the high-byte read, so the two bytes always belong together. A latch-only option sends writes to the reload latch alone. The new value then reaches the counter at the next underflow.

Top module: `meas_timer16`

## Requirements
- R1: After reset every register is zero: all read data reads 0, the port output is 2'b00, both interrupt outputs are low and the counter is stopped.
- R2: A bus write to address 0 stores a low byte in a holding register. A write to address 1 forms {high, held low}. When mode bit 3 is 0, that value loads both the counter and the latch.
- R3: A read of address 1 returns the counter's high byte and captures the low byte. A later read of address 0 returns that captured byte, even if the counter has moved since. Read data appears the cycle after the strobe.
- R4: The mode register (address 2) uses these fields: bits [1:0] select the mode (0 timer, 1 period, 2 event, 3 pulse-width), bit 2 selects the active edge (0 rising, 1 falling), bit 3 selects latch-only writes, bit 4 enables the port and bit 5 runs the counter. With bit 5 at 0 the counter does not change.
- R5: Each counting step decrements the counter. A step at 0 is an underflow. It reloads the latch value and gives a one-cycle pulse on irq_unf_o, so the underflow period is latch+1 steps.
- R6: With mode bit 3 at 1, a high-byte write updates only the latch. The counter keeps its value until the next underflow loads the new value.
- R7: In latch-only mode, a high-byte write in the same cycle as a step that would underflow loads both counter and latch with the written value. No step is taken and no underflow pulse is raised that cycle.
- R8: In period mode, the selected edge of ext_i raises irq_edge_o and reloads the counter from the latch. The other edge does neither.
- R9: In the measurement modes, reads return the count frozen at the edge-triggered reload until one complete high-then-low read has been made. After that, reads show the live counter again.
- R10: In pulse-width mode both rising and falling edges of ext_i reload the counter and raise irq_edge_o, whatever mode bit 2 says.
- R11: In event mode the counter decrements once per selected edge of ext_i, and tick_i has no effect.
- R12: Address 3 holds the port data. While mode bit 4 is 1, rt_o takes bits [1:0] of that data at each underflow. Data changed between underflows is not seen until the next one.
- R13: When mode bit 4 changes from 0 to 1, rt_o takes the stored port data at once, without waiting for an underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-enable strobe from the prescaler |
| ext_i | input | 1 | Asynchronous external input |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | 2 | Byte address: 0 timer low, 1 timer high, 2 mode, 3 port data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_unf_o | output | 1 | Underflow interrupt pulse |
| irq_edge_o | output | 1 | External edge interrupt pulse |
| rt_o | output | 2 | Real-time output port |

## Verification
Any corruption of the counter, the latch or the frozen capture value shows up in one of two places. The first is the next high-then-low read, two cycles after the strobe. The second is the spacing between underflow pulses, which falls within latch+1 steps. A wrong read-capture or hold-valid flag shows up as a mismatched byte pair or a stale value on the second read. A stuck port-update path shows up on rt_o at the first underflow or enable after the fault.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    MD_TIMER  = 2'd0,
    MD_PERIOD = 2'd1,
    MD_EVENT  = 2'd2,
    MD_PWHL   = 2'd3
  } mt_mode_e;

  localparam logic [1:0] A_CNT_LO = 2'd0;
  localparam logic [1:0] A_CNT_HI = 2'd1;
  localparam logic [1:0] A_MODE   = 2'd2;
  localparam logic [1:0] A_RTDATA = 2'd3;

  localparam int B_EDGE_FALL  = 2;
  localparam int B_LATCH_ONLY = 3;
  localparam int B_RT_EN      = 4;
  localparam int B_RUN        = 5;
endpackage

// File: rtl/mt_edge.sv
module mt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/mt_core.sv
module mt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             meas_ev_i,
  input  logic             wr_hi_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic             latch_only_i,
  input  logic             rd_lo_i,
  output logic [CNT_W-1:0] view_o,
  output logic             unf_o,
  output logic             irq_unf_o
);
  logic [CNT_W-1:0] cnt_q, latch_q, hold_q;
  logic             hold_vld_q;
  logic             at_zero, collide, load_direct;

  assign at_zero     = (cnt_q == '0);
  assign collide     = wr_hi_i & latch_only_i & step_i & at_zero;
  assign load_direct = wr_hi_i & (~latch_only_i | collide);
  assign unf_o       = step_i & at_zero & ~wr_hi_i & ~meas_ev_i;
  assign view_o      = hold_vld_q ? hold_q : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      latch_q    <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      irq_unf_o  <= 1'b0;
    end else begin
      irq_unf_o <= unf_o;
      if (wr_hi_i) latch_q <= wr_val_i;
      if (load_direct) begin
        cnt_q <= wr_val_i;
      end else if (meas_ev_i) begin
        hold_q <= cnt_q;
        cnt_q  <= latch_q;
      end else if (step_i && !wr_hi_i) begin
        cnt_q <= at_zero ? latch_q : cnt_q - 1'b1;
      end
      if (load_direct)    hold_vld_q <= 1'b0;
      else if (meas_ev_i) hold_vld_q <= 1'b1;
      else if (rd_lo_i)   hold_vld_q <= 1'b0;
    end
  end

  AST_UNF_RELOAD: assert property (@(posedge clk) disable iff (rst)
    unf_o |=> (cnt_q == $past(latch_q))); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !meas_ev_i && !wr_hi_i) |=> $stable(cnt_q)); // R4
  AST_LATCH_ONLY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_hi_i && latch_only_i && !(step_i && at_zero) && !meas_ev_i) |=> $stable(cnt_q)); // R6
  AST_COLLIDE_LOAD: assert property (@(posedge clk) disable iff (rst)
    collide |=> (cnt_q == latch_q) && !irq_unf_o); // R7
endmodule

// File: rtl/mt_rtport.sv
module mt_rtport #(
  parameter int RT_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic            unf_i,
  input  logic [RT_W-1:0] data_i,
  output logic [RT_W-1:0] port_o
);
  logic en_q, load;

  assign load = en_i & (~en_q | unf_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      port_o <= '0;
    end else begin
      en_q <= en_i;
      if (load) port_o <= data_i;
    end
  end

  AST_RT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(en_i && (!en_q || unf_i)) |=> $stable(port_o)); // R12
endmodule

// File: rtl/meas_timer16.sv
module meas_timer16 #(
  parameter int BUS_W       = 8,
  parameter int RT_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ext_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_unf_o,
  output logic             irq_edge_o,
  output logic [RT_W-1:0]  rt_o
);
  import mt_pkg::*;
  localparam int CNT_W = 2 * BUS_W;

  logic [BUS_W-1:0] mode_q, rtdat_q, tmp_lo_q, lo_buf_q;
  logic [CNT_W-1:0] view;
  logic             rise, fall, sel_edge, any_edge, run;
  logic             step, meas_ev, edge_irq, unf;
  logic             wr_hi, rd_hi, rd_lo;
  mt_mode_e         mode;

  assign mode     = mt_mode_e'(mode_q[1:0]);
  assign run      = mode_q[B_RUN];
  assign sel_edge = mode_q[B_EDGE_FALL] ? fall : rise;
  assign any_edge = rise | fall;
  assign wr_hi    = wr_i & (addr_i == A_CNT_HI);
  assign rd_hi    = rd_i & (addr_i == A_CNT_HI);
  assign rd_lo    = rd_i & (addr_i == A_CNT_LO);

  always_comb begin
    step     = 1'b0;
    meas_ev  = 1'b0;
    edge_irq = sel_edge;
    case (mode)
      MD_TIMER:  step = run & tick_i;
      MD_PERIOD: begin step = run & tick_i; meas_ev = run & sel_edge; end
      MD_EVENT:  step = run & sel_edge;
      MD_PWHL:   begin step = run & tick_i; meas_ev = run & any_edge; edge_irq = any_edge; end
      default:   step = 1'b0;
    endcase
  end

  mt_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin_i(ext_i), .rise_o(rise), .fall_o(fall)
  );

  mt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .step_i(step), .meas_ev_i(meas_ev),
    .wr_hi_i(wr_hi), .wr_val_i({wdata_i, tmp_lo_q}),
    .latch_only_i(mode_q[B_LATCH_ONLY]), .rd_lo_i(rd_lo),
    .view_o(view), .unf_o(unf), .irq_unf_o(irq_unf_o)
  );

  mt_rtport #(.RT_W(RT_W)) u_rt (
    .clk(clk), .rst(rst), .en_i(mode_q[B_RT_EN]), .unf_i(unf),
    .data_i(rtdat_q[RT_W-1:0]), .port_o(rt_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      rtdat_q    <= '0;
      tmp_lo_q   <= '0;
      lo_buf_q   <= '0;
      rdata_o    <= '0;
      irq_edge_o <= 1'b0;
    end else begin
      irq_edge_o <= edge_irq;
      if (wr_i) begin
        case (addr_i)
          A_CNT_LO: tmp_lo_q <= wdata_i;
          A_MODE:   mode_q   <= wdata_i;
          A_RTDATA: rtdat_q  <= wdata_i;
          default:  ;
        endcase
      end
      if (rd_hi) lo_buf_q <= view[BUS_W-1:0];
      if (rd_i) begin
        case (addr_i)
          A_CNT_LO: rdata_o <= lo_buf_q;
          A_CNT_HI: rdata_o <= view[CNT_W-1:BUS_W];
          A_MODE:   rdata_o <= mode_q;
          default:  rdata_o <= rtdat_q;
        endcase
      end
    end
  end

  AST_PERIOD_OTHER_EDGE: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_PERIOD && !mode_q[B_EDGE_FALL] && fall) |=> !irq_edge_o); // R8
  AST_PWHL_BOTH: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_PWHL && any_edge) |=> irq_edge_o); // R10
endmodule

// File: tb/meas_timer16_bench.sv
`timescale 1ns/1ps
module meas_timer16_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, ext = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_unf, irq_edge;
  logic [1:0] rt;
  int n_chk = 0, n_fail = 0, n_unf = 0, n_edge = 0;

  always #2.5 clk = ~clk;

  meas_timer16 u_meas_timer16 (
    .clk(clk), .rst(rst), .tick_i(tick), .ext_i(ext), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_unf_o(irq_unf), .irq_edge_o(irq_edge), .rt_o(rt)
  );

  always @(negedge clk) begin
    if (!rst && irq_unf)  n_unf++;
    if (!rst && irq_edge) n_edge++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wr16(input logic [15:0] v);
    bus_wr(2'd0, v[7:0]);
    bus_wr(2'd1, v[15:8]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    bus_rd(2'd1, h);
    bus_rd(2'd0, l);
    v = {h, l};
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    idle(n);
    tick = 1'b0;
  endtask

  task automatic pulse_ext(input logic lvl);
    ext = lvl;
    idle(5);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 rt_o", rt, 0);
    chk("R1 irqs", {irq_unf, irq_edge}, 0);
    bus_rd(2'd2, d);
    chk("R1 mode", d, 0);
  endtask

  task automatic t_rw;
    logic [7:0] h, l;
    bus_wr(2'd2, 8'h00);
    wr16(16'h1234);
    bus_rd(2'd1, h);
    bus_rd(2'd0, l);
    chk("R2 high", h, 8'h12);
    chk("R2 low", l, 8'h34);
  endtask

  task automatic t_order_and_stop;
    logic [7:0] h, l;
    logic [15:0] v;
    bus_wr(2'd2, 8'h20);
    wr16(16'h0100);
    bus_rd(2'd1, h);
    ticks(1);
    bus_rd(2'd0, l);
    chk("R3 high", h, 8'h01);
    chk("R3 low snapshot", l, 8'h00);
    bus_wr(2'd2, 8'h00);
    ticks(5);
    rd16(v);
    chk("R4 stopped", v, 16'h00FF);
  endtask

  task automatic t_underflow;
    int n0;
    logic [15:0] v;
    bus_wr(2'd2, 8'h20);
    wr16(16'h0003);
    n0 = n_unf;
    ticks(12);
    idle(2);
    chk("R5 underflow count", n_unf - n0, 3);
    rd16(v);
    chk("R5 reload value", v, 16'h0003);
  endtask

  task automatic t_latch_only;
    logic [15:0] v;
    bus_wr(2'd2, 8'h20);
    wr16(16'h0002);
    bus_wr(2'd2, 8'h28);
    wr16(16'h0005);
    rd16(v);
    chk("R6 counter kept", v, 16'h0002);
    ticks(3);
    rd16(v);
    chk("R6 loaded at underflow", v, 16'h0005);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    int n0;
    bus_wr(2'd2, 8'h20);
    wr16(16'h0001);
    bus_wr(2'd2, 8'h28);
    ticks(1);
    bus_wr(2'd0, 8'h07);
    n0 = n_unf;
    tick = 1'b1;
    bus_wr(2'd1, 8'h00);
    tick = 1'b0;
    idle(2);
    chk("R7 no underflow pulse", n_unf - n0, 0);
    rd16(v);
    chk("R7 counter loaded, no step", v, 16'h0007);
  endtask

  task automatic t_rtport;
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd3, 8'h01);
    idle(2);
    chk("R12 disabled keeps port", rt, 0);
    bus_wr(2'd2, 8'h30);
    idle(2);
    chk("R13 enable drives at once", rt, 1);
    wr16(16'h0001);
    bus_wr(2'd3, 8'h02);
    idle(2);
    chk("R12 waits for underflow", rt, 1);
    ticks(2);
    chk("R12 updated at underflow", rt, 2);
    bus_wr(2'd2, 8'h00);
  endtask

  task automatic t_period;
    logic [15:0] v;
    int e0;
    pulse_ext(1'b0);
    bus_wr(2'd2, 8'h21);
    wr16(16'h0010);
    ticks(2);
    e0 = n_edge;
    pulse_ext(1'b1);
    chk("R8 irq on rising", n_edge - e0, 1);
    rd16(v);
    chk("R9 held count", v, 16'h000E);
    rd16(v);
    chk("R9 live after read", v, 16'h0010);
    ticks(1);
    e0 = n_edge;
    pulse_ext(1'b0);
    chk("R8 no irq on falling", n_edge - e0, 0);
    rd16(v);
    chk("R8 no reload on falling", v, 16'h000F);
  endtask

  task automatic t_pwhl;
    logic [15:0] v;
    int e0;
    bus_wr(2'd2, 8'h23);
    wr16(16'h0020);
    ticks(1);
    pulse_ext(1'b1);
    rd16(v);
    chk("R10 rising held", v, 16'h001F);
    rd16(v);
    chk("R9 live after read", v, 16'h0020);
    ticks(2);
    e0 = n_edge;
    pulse_ext(1'b0);
    chk("R10 irq on falling", n_edge - e0, 1);
    rd16(v);
    chk("R10 falling held", v, 16'h001E);
  endtask

  task automatic t_event;
    logic [15:0] v;
    bus_wr(2'd2, 8'h22);
    wr16(16'h0005);
    tick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      pulse_ext(1'b1);
      pulse_ext(1'b0);
    end
    tick = 1'b0;
    rd16(v);
    chk("R11 event count", v, 16'h0002);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset;
    t_rw;
    t_order_and_stop;
    t_underflow;
    t_latch_only;
    t_collide;
    t_rtport;
    t_period;
    t_pwhl;
    t_event;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule